// File: doc/BRIEF.md
# Special Bus Cycle Decoder and Responder

This block sits on the system side of a processor bus that has 64-bit data and 32-bit addresses. It watches each address strobe. A cycle counts as special only when the strobe is active and the three control lines show data/code = 0, memory/IO = 0 and write/read = 1. When a special cycle starts, the block captures the active-low byte enables and the address field. It classifies the cycle from the captured byte enables and the two lowest address bits, then answers with a one-clock active-low ready strobe.

The ready strobe comes after a wait of 0 to 7 clocks. The wait count is sampled together with the strobe. In the clock where ready is low, exactly one event output pulses high. That output names the cycle kind, or flags it as unknown when the encoding does not match any kind. An unknown special cycle is still acknowledged, so the processor never stalls on it. Memory cycles, I/O cycles and ordinary data cycles get no response from this block.

The bus pins are plain sampled strobes with no valid/ready pairing, and the block never stalls the bus. While one special cycle is pending, any new strobe is dropped. The processor must not start a new special cycle before it has seen ready for the current one.

Top module: `spc_cycle_responder`

## Requirements
- R1: A cycle is taken only when, at a clock edge, bus_strobe_n = 0, bus_dc = 0, bus_mio = 0 and bus_wr = 1 while the block is idle. Any other combination produces no ready and no event, and the block stays idle.
- R2: Captured byte enables 8'hFB with address bits [4:3] = 2'b10 decode as stop grant and pulse evt_stop_grant.
- R3: Byte enables 8'hEF with bits [4:3] = 2'b00 decode as flush acknowledge (evt_flush_ack). Byte enables 8'hF7 with 2'b00 decode as writeback (evt_writeback).
- R4: With bits [4:3] = 2'b00, byte enables 8'hFB decode as halt (evt_halt), 8'hFD as cache flush (evt_flush), and 8'hFE as shutdown (evt_shutdown).
- R5: If address bits [31:5] are not all zero, or the byte-enable/bit-pair combination is not listed in R2–R4, the cycle pulses evt_unknown and is still acknowledged.
- R6: Call the capture edge edge 0, and let W be the cfg_wait value sampled on that edge. rdy_n is low only between edge W and edge W+1, which is exactly one clock.
- R7: Strobes seen at any edge after the capture edge, up to and including the edge that ends the ready clock, are ignored. The event reported is the one for the originally captured values.
- R8: Event outputs are high only in the clock where rdy_n is low, and exactly one of them is high in that clock.
- R9: The synchronous active-low reset rst_n sets rdy_n high, drives all events low, and discards any pending cycle.
- R10: A change of cfg_wait after the capture edge does not move the ready of the cycle already pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wait | input | 3 | Wait clocks before ready, sampled at capture |
| bus_strobe_n | input | 1 | Address strobe, active low |
| bus_dc | input | 1 | Data/code control line |
| bus_mio | input | 1 | Memory/IO control line |
| bus_wr | input | 1 | Write/read control line |
| bus_be_n | input | 8 | Byte enables, active low |
| bus_addr | input | 29 | Address bits [31:3] |
| rdy_n | output | 1 | Ready strobe to the processor, active low |
| evt_stop_grant | output | 1 | Stop grant cycle pulse |
| evt_flush_ack | output | 1 | Flush acknowledge cycle pulse |
| evt_writeback | output | 1 | Writeback cycle pulse |
| evt_halt | output | 1 | Halt cycle pulse |
| evt_flush | output | 1 | Cache flush cycle pulse |
| evt_shutdown | output | 1 | Shutdown cycle pulse |
| evt_unknown | output | 1 | Unrecognised special cycle pulse |

## Verification
The bench builds the block with its default parameters: a 32-bit address and a 3-bit wait field. With these defaults every wait value from 0 through 7 can be reached, and the random runs cover all of them. The full 29-bit address field is exposed, so stray upper bits can be forced one at a time to reach the unknown path. Because the wait field is only 3 bits wide, the longest pending window is short enough to hold the strobe asserted across all of it. This tests that strobes are ignored at every edge until ready is given.

// File: rtl/spc_pkg.sv
package spc_pkg;
  localparam int SPC_BE_W   = 8;
  localparam int SPC_EVT_N  = 7;

  // event index order is also the bit order of the event vector
  typedef enum logic [2:0] {
    SPC_NONE      = 3'd0,
    SPC_STOP_GNT  = 3'd1,
    SPC_FLUSH_ACK = 3'd2,
    SPC_WRBACK    = 3'd3,
    SPC_HALT      = 3'd4,
    SPC_INVAL     = 3'd5,
    SPC_SHUTDOWN  = 3'd6,
    SPC_UNKNOWN   = 3'd7
  } spc_kind_e;

  localparam logic [SPC_BE_W-1:0] BE_CODE_FB = 8'hFB;
  localparam logic [SPC_BE_W-1:0] BE_CODE_EF = 8'hEF;
  localparam logic [SPC_BE_W-1:0] BE_CODE_F7 = 8'hF7;
  localparam logic [SPC_BE_W-1:0] BE_CODE_FD = 8'hFD;
  localparam logic [SPC_BE_W-1:0] BE_CODE_FE = 8'hFE;
endpackage

// File: rtl/spc_capture.sv
module spc_capture
  import spc_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ADDR_LO = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    idle,
  input  logic                    strobe_n,
  input  logic                    dc,
  input  logic                    mio,
  input  logic                    wr,
  input  logic [SPC_BE_W-1:0]     be_n,
  input  logic [ADDR_W-1:ADDR_LO] addr,
  output logic                    take,
  output logic [SPC_BE_W-1:0]     hold_be,
  output logic [ADDR_W-1:ADDR_LO] hold_addr
);
  logic ctrl_special;

  // fixed control combination marks a special cycle
  assign ctrl_special = !dc && !mio && wr;
  assign take         = idle && !strobe_n && ctrl_special;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_be   <= '1;
      hold_addr <= '0;
    end else if (take) begin
      hold_be   <= be_n;
      hold_addr <= addr;
    end
  end
endmodule

// File: rtl/spc_decode.sv
module spc_decode
  import spc_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ADDR_LO = 3
) (
  input  logic [SPC_BE_W-1:0]     hold_be,
  input  logic [ADDR_W-1:ADDR_LO] hold_addr,
  output spc_kind_e               kind
);
  localparam int SEL_LO = ADDR_LO;
  localparam int SEL_HI = ADDR_LO + 1;
  localparam int UP_LO  = ADDR_LO + 2;

  logic       upper_clear;
  logic [1:0] sel;

  assign upper_clear = ~|hold_addr[ADDR_W-1:UP_LO];
  assign sel         = hold_addr[SEL_HI:SEL_LO];

  always_comb begin
    kind = SPC_UNKNOWN;
    if (upper_clear) begin
      unique case (sel)
        2'b10: if (hold_be == BE_CODE_FB) kind = SPC_STOP_GNT;
        2'b00: begin
          case (hold_be)
            BE_CODE_EF: kind = SPC_FLUSH_ACK;
            BE_CODE_F7: kind = SPC_WRBACK;
            BE_CODE_FB: kind = SPC_HALT;
            BE_CODE_FD: kind = SPC_INVAL;
            BE_CODE_FE: kind = SPC_SHUTDOWN;
            default:    kind = SPC_UNKNOWN;
          endcase
        end
        default: kind = SPC_UNKNOWN;
      endcase
    end
  end
endmodule

// File: rtl/spc_ready_timer.sv
module spc_ready_timer #(
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [WAIT_W-1:0] wait_in,
  output logic              busy,
  output logic              fire
);
  logic [WAIT_W-1:0] remain;

  assign fire = busy && (remain == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      remain <= '0;
    end else if (take) begin
      busy   <= 1'b1;
      remain <= wait_in;
    end else if (fire) begin
      busy   <= 1'b0;
    end else if (busy) begin
      remain <= remain - 1'b1;
    end
  end
endmodule

// File: rtl/spc_cycle_responder.sv
module spc_cycle_responder
  import spc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WAIT_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [WAIT_W-1:0]   cfg_wait,
  input  logic                bus_strobe_n,
  input  logic                bus_dc,
  input  logic                bus_mio,
  input  logic                bus_wr,
  input  logic [SPC_BE_W-1:0] bus_be_n,
  input  logic [ADDR_W-1:3]   bus_addr,
  output logic                rdy_n,
  output logic                evt_stop_grant,
  output logic                evt_flush_ack,
  output logic                evt_writeback,
  output logic                evt_halt,
  output logic                evt_flush,
  output logic                evt_shutdown,
  output logic                evt_unknown
);
  localparam int ADDR_LO = 3;

  logic                    busy;
  logic                    take;
  logic                    fire;
  logic [SPC_BE_W-1:0]     hold_be;
  logic [ADDR_W-1:ADDR_LO] hold_addr;
  spc_kind_e               kind;
  logic [SPC_EVT_N-1:0]    evt_vec;

  spc_capture #(.ADDR_W(ADDR_W), .ADDR_LO(ADDR_LO)) u_capture (
    .clk(clk), .rst_n(rst_n), .idle(!busy),
    .strobe_n(bus_strobe_n), .dc(bus_dc), .mio(bus_mio), .wr(bus_wr),
    .be_n(bus_be_n), .addr(bus_addr),
    .take(take), .hold_be(hold_be), .hold_addr(hold_addr)
  );

  spc_decode #(.ADDR_W(ADDR_W), .ADDR_LO(ADDR_LO)) u_decode (
    .hold_be(hold_be), .hold_addr(hold_addr), .kind(kind)
  );

  spc_ready_timer #(.WAIT_W(WAIT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .take(take), .wait_in(cfg_wait),
    .busy(busy), .fire(fire)
  );

  genvar k;
  generate
    for (k = 0; k < SPC_EVT_N; k++) begin : g_evt
      assign evt_vec[k] = fire && (kind == spc_kind_e'(k + 1));
    end
  endgenerate

  assign rdy_n          = !fire;
  assign evt_stop_grant = evt_vec[0];
  assign evt_flush_ack  = evt_vec[1];
  assign evt_writeback  = evt_vec[2];
  assign evt_halt       = evt_vec[3];
  assign evt_flush      = evt_vec[4];
  assign evt_shutdown   = evt_vec[5];
  assign evt_unknown    = evt_vec[6];
endmodule

// File: rtl/spc_cycle_checker.sv
module spc_cycle_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rdy_n,
  input logic [6:0]        evt_vec,
  input logic              busy,
  input logic              bus_strobe_n,
  input logic              bus_dc,
  input logic              bus_mio,
  input logic              bus_wr,
  input logic [7:0]        hold_be,
  input logic [ADDR_W-1:3] hold_addr
);
  a_r6_rdy_single_clock: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy_n |=> rdy_n);

  a_r8_evt_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(evt_vec));

  a_r8_evt_only_with_rdy: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_vec != 7'd0) |-> !rdy_n);

  a_r5_ack_always_classified: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy_n |-> ($countones(evt_vec) == 1));

  a_r7_capture_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(hold_be) && $stable(hold_addr)));

  a_r1_unqualified_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (bus_strobe_n || bus_dc || bus_mio || !bus_wr)) |=> rdy_n);
endmodule

bind spc_cycle_responder spc_cycle_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rdy_n(rdy_n), .evt_vec(evt_vec), .busy(busy),
  .bus_strobe_n(bus_strobe_n), .bus_dc(bus_dc), .bus_mio(bus_mio),
  .bus_wr(bus_wr), .hold_be(hold_be), .hold_addr(hold_addr)
);

// File: tb/spc_cycle_responder_bench.sv
module spc_cycle_responder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_wait = 3'd0;
  logic        bus_strobe_n = 1'b1;
  logic        bus_dc = 1'b1, bus_mio = 1'b1, bus_wr = 1'b0;
  logic [7:0]  bus_be_n = 8'hFF;
  logic [31:3] bus_addr = '0;
  logic        rdy_n;
  logic        e_sg, e_fa, e_wb, e_ht, e_fl, e_sd, e_un;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  always #2 clk = ~clk;

  spc_cycle_responder u_spc_cycle_responder (
    .clk(clk), .rst_n(rst_n), .cfg_wait(cfg_wait),
    .bus_strobe_n(bus_strobe_n), .bus_dc(bus_dc), .bus_mio(bus_mio),
    .bus_wr(bus_wr), .bus_be_n(bus_be_n), .bus_addr(bus_addr),
    .rdy_n(rdy_n), .evt_stop_grant(e_sg), .evt_flush_ack(e_fa),
    .evt_writeback(e_wb), .evt_halt(e_ht), .evt_flush(e_fl),
    .evt_shutdown(e_sd), .evt_unknown(e_un)
  );

  // {rdy_n, unknown, shutdown, flush, halt, writeback, flushack, stopgrant}
  function automatic logic [7:0] observed();
    return {rdy_n, e_un, e_sd, e_fl, e_ht, e_wb, e_fa, e_sg};
  endfunction

  // expected one-hot event bit from requirement tables R2..R5
  function automatic logic [6:0] expect_evt(logic [7:0] be, logic [31:3] a);
    if (a[31:5] != '0) return 7'b100_0000;
    if (a[4:3] == 2'b10) return (be == 8'hFB) ? 7'b000_0001 : 7'b100_0000;
    if (a[4:3] != 2'b00) return 7'b100_0000;
    case (be)
      8'hEF:   return 7'b000_0010;
      8'hF7:   return 7'b000_0100;
      8'hFB:   return 7'b000_1000;
      8'hFD:   return 7'b001_0000;
      8'hFE:   return 7'b010_0000;
      default: return 7'b100_0000;
    endcase
  endfunction

  task automatic check(string req, logic [7:0] exp);
    n_checks++;
    if (observed() !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at cycle %0d", req, observed(), exp, cyc);
    end
  endtask

  // one bus cycle; hold keeps a competing strobe active until the ready edge
  task automatic run_cycle(string req, logic [7:0] be, logic [31:3] a,
                           logic dc, logic mio, logic wr, int w, bit hold);
    logic qual;
    qual = !dc && !mio && wr;
    @(negedge clk);
    cfg_wait = 3'(w);
    bus_strobe_n = 1'b0; bus_dc = dc; bus_mio = mio; bus_wr = wr;
    bus_be_n = be; bus_addr = a;
    for (int i = 0; i <= w + 3; i++) begin
      @(negedge clk);
      if (i == 0) cfg_wait = 3'(7 - w);  // R10: late change must not matter
      if (hold && i < w) begin
        bus_strobe_n = 1'b0; bus_dc = 1'b0; bus_mio = 1'b0; bus_wr = 1'b1;
        bus_be_n = (be == 8'hFE) ? 8'hEF : 8'hFE; bus_addr = '0;
      end else begin
        bus_strobe_n = 1'b1; bus_dc = 1'b1; bus_mio = 1'b1; bus_wr = 1'b0;
      end
      if (qual && i == w) check(req, {1'b0, expect_evt(be, a)});
      else                check(req, 8'h80);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset state", 8'h80);
    rst_n = 1'b1;

    // directed decode, both wait extremes
    for (int w = 0; w < 8; w += 7) begin
      run_cycle("R2 stop grant",  8'hFB, 29'h2, 0, 0, 1, w, 0);
      run_cycle("R3 flush ack",   8'hEF, 29'h0, 0, 0, 1, w, 0);
      run_cycle("R3 writeback",   8'hF7, 29'h0, 0, 0, 1, w, 0);
      run_cycle("R4 halt",        8'hFB, 29'h0, 0, 0, 1, w, 0);
      run_cycle("R4 flush",       8'hFD, 29'h0, 0, 0, 1, w, 0);
      run_cycle("R4 shutdown",    8'hFE, 29'h0, 0, 0, 1, w, 0);
      run_cycle("R5 upper addr",  8'hFB, 29'h4, 0, 0, 1, w, 0);
      run_cycle("R5 bad be",      8'h7F, 29'h0, 0, 0, 1, w, 0);
      run_cycle("R5 bad sel",     8'hEF, 29'h1, 0, 0, 1, w, 0);
      run_cycle("R1 memory read", 8'hFB, 29'h0, 1, 1, 0, w, 0);
      run_cycle("R1 io write",    8'hFB, 29'h0, 1, 0, 1, w, 0);
    end
    // R7: strobes held through the pending window
    for (int w = 0; w < 8; w++)
      run_cycle("R7 ignore busy strobe", 8'hF7, 29'h0, 0, 0, 1, w, 1);
    run_cycle("R6 R8 single ready", 8'hFE, 29'h0, 0, 0, 1, 3, 1);

    // R9: reset mid-cycle discards pending
    @(negedge clk);
    cfg_wait = 3'd7; bus_strobe_n = 1'b0; bus_dc = 1'b0; bus_mio = 1'b0;
    bus_wr = 1'b1; bus_be_n = 8'hFB; bus_addr = '0;
    @(negedge clk);
    bus_strobe_n = 1'b1; bus_dc = 1'b1; bus_mio = 1'b1; bus_wr = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      check("R9 pending cleared", 8'h80);
    end

    // constrained random mix
    void'($urandom(32'h5EC1A1));
    for (int n = 0; n < 200; n++) begin
      int sel, w;
      logic [7:0] be;
      logic [31:3] a;
      logic dc, mio, wr;
      logic [7:0] codes [6] = '{8'hFB, 8'hEF, 8'hF7, 8'hFB, 8'hFD, 8'hFE};
      sel = int'($urandom_range(0, 99));
      w   = int'($urandom_range(0, 7));
      dc = 1'b0; mio = 1'b0; wr = 1'b1;
      be = codes[$urandom_range(0, 5)];
      a  = (be == 8'hFB && $urandom_range(0, 1) == 1) ? 29'h2 : 29'h0;
      if (sel < 15)       be = 8'($urandom);
      else if (sel < 20)  a[31:5] = 27'(1 << $urandom_range(0, 26));
      else if (sel < 30) begin
        {dc, mio, wr} = 3'($urandom_range(0, 7));
        if ({dc, mio, wr} == 3'b001) dc = 1'b1;
      end
      run_cycle("R1 R6 R8 random", be, a, dc, mio, wr, w, sel >= 90);
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule